// File: doc/BRIEF.md
# Store drain buffer for a write-through cache

This block sits between a write-through cache and main memory. The processor writes each store into the cache and also hands it to this block as an address/data pair. The block queues these pairs and retires them to memory one at a time through a valid/ready handshake, so the processor does not wait for memory on a store. It waits only when every slot is occupied and memory cannot take an entry in that same cycle.

The block also guards reads that go to memory. When the cache misses on a read, the refill request passes through this block. Every pending entry is compared with the request's word address in parallel. If any pending entry holds that address, the request is held back until that entry has been written to memory. A refill therefore never returns data that a queued store is about to overwrite.

Top module: `store_drain_buffer`

## Requirements
- R1: While reset is asserted and after it is released, the buffer is empty: `empty`=1, `full`=0, `level`=0 and `mw_valid`=0.
- R2: When the buffer is not full, `st_ready` is 1 and a store with `st_valid`=1 is accepted. `level` rises by one, unless an entry drains in the same cycle, in which case it is unchanged.
- R3: When the buffer is full and memory does not accept the head entry in that cycle (`mw_ready`=0), `st_ready` is 0 and `level` stays at DEPTH.
- R4: Entries reach memory strictly in the order the stores were accepted, with the address and data exactly as accepted.
- R5: `mw_valid` is 1 exactly when the buffer holds at least one entry. While `mw_valid`=1 and `mw_ready`=0, `mw_addr` and `mw_data` hold their values.
- R6: When the buffer is full and `mw_ready`=1, `st_ready` is 1. A store offered in that cycle is accepted into the slot being freed and `level` stays at DEPTH.
- R7: A read request is held whenever an entry with the same word address is pending at the start of the cycle. While held, `rd_out_valid`=0 and `rd_in_ready`=0. Otherwise `rd_out_valid`=`rd_in_valid`, `rd_in_ready`=`rd_out_ready` and `rd_out_addr`=`rd_in_addr`.
- R8: `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered by the processor |
| st_ready | output | 1 | Store accepted; low means stall |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| mw_valid | output | 1 | Head entry offered to memory |
| mw_ready | input | 1 | Memory accepts the head entry |
| mw_addr | output | AW | Head entry word address |
| mw_data | output | DW | Head entry data |
| rd_in_valid | input | 1 | Read-miss refill request from the cache |
| rd_in_ready | output | 1 | Refill request taken by memory |
| rd_in_addr | input | AW | Refill word address |
| rd_out_valid | output | 1 | Refill request forwarded to memory |
| rd_out_ready | input | 1 | Memory accepts the refill request |
| rd_out_addr | output | AW | Forwarded refill word address |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entries pending |
| level | output | $clog2(DEPTH+1) | Number of pending entries |

## Verification
The hardest situation to reach is a refill held against an entry that is not at the head, while the head drains slowly and a new store lands in the slot freed by a full-buffer drain. The stimulus sweeps every 4-cycle pattern of memory readiness against every 4-cycle pattern of store offers. It draws both store and refill addresses from a pool of five words, so matches against deep entries occur in many of those cycles. A running model of the queue in the bench predicts the handshakes, the head and the hold on every cycle.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  // Advance a circular slot index that wraps at depth-1.
  function automatic int unsigned sdb_step(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/sdb_ptr_ctrl.sv
module sdb_ptr_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  import sdb_pkg::*;

  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] lvl_q, lvl_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (push) wptr_d = PW'(sdb_step(int'(wptr_q), DEPTH));
    if (pop)  rptr_d = PW'(sdb_step(int'(rptr_q), DEPTH));
    case ({push, pop})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_d;
      if (pop)  rptr_q <= rptr_d;
      if (push != pop) lvl_q <= lvl_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign level = lvl_q;
  assign full  = (lvl_q == CW'(DEPTH));
  assign empty = (lvl_q == '0);

  // R3: with no drain, a full buffer remains full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full);
  // R2: occupancy moves by at most one per cycle
  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level)) || (level == $past(level) + 1'b1) ||
             (level == $past(level) - 1'b1));
  // R8: the last free slot taken without a drain makes the buffer full
  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH - 1)) && push && !pop |=> full);
endmodule

// File: rtl/sdb_entry_store.sv
module sdb_entry_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] wptr,
  input  logic [PW-1:0] rptr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] match;

  always_comb begin
    vld_d = vld_q;
    if (pop)  vld_d[rptr] = 1'b0;
    if (push) vld_d[wptr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (push || pop) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wptr] <= wr_addr;
      data_q[wptr] <= wr_data;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (addr_q[g] == probe_addr);
  end

  assign probe_hit = |match;
  assign head_addr = addr_q[rptr];
  assign head_data = data_q[rptr];

  // R4: an entry is never written over while it is still pending
  p_no_clobber_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push && vld_q[wptr] |-> pop && (rptr == wptr));
endmodule

// File: rtl/sdb_read_gate.sv
module sdb_read_gate #(
  parameter int AW = 30
) (
  input  logic          hit,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  assign out_valid = in_valid && !hit;
  assign in_ready  = out_ready && !hit;
  assign out_addr  = in_addr;
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  input  logic          rd_in_valid,
  output logic          rd_in_ready,
  input  logic [AW-1:0] rd_in_addr,
  output logic          rd_out_valid,
  input  logic          rd_out_ready,
  output logic [AW-1:0] rd_out_addr,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level
);
  logic          push, pop, hit;
  logic [PW-1:0] wptr, rptr;

  assign mw_valid = !empty;
  assign pop      = mw_valid && mw_ready;
  assign st_ready = !full || mw_ready;
  assign push     = st_valid && st_ready;

  sdb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wptr(wptr), .rptr(rptr), .level(level), .full(full), .empty(empty)
  );

  sdb_entry_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wptr(wptr), .rptr(rptr), .wr_addr(st_addr), .wr_data(st_data),
    .head_addr(mw_addr), .head_data(mw_data),
    .probe_addr(rd_in_addr), .probe_hit(hit)
  );

  sdb_read_gate #(.AW(AW)) u_gate (
    .hit(hit), .in_valid(rd_in_valid), .in_ready(rd_in_ready), .in_addr(rd_in_addr),
    .out_valid(rd_out_valid), .out_ready(rd_out_ready), .out_addr(rd_out_addr)
  );

  // R5: a stalled head entry holds its address and data
  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));
  // R7: a refill blocked while memory is ready implies a pending entry
  p_hold_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in_valid && rd_out_ready && !rd_in_ready |-> !empty);
  // R6: a full buffer that drains still accepts a store
  p_full_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && mw_ready |-> st_ready);
  // R1: state is empty in the first cycle after reset
  p_reset_empty_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> empty && !mw_valid);
endmodule

// File: tb/sim_store_drain_buffer.sv
`timescale 1ns/1ps
module sim_store_drain_buffer;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, st_ready, mw_valid, mw_ready;
  logic [AW-1:0] st_addr, mw_addr, rd_in_addr, rd_out_addr;
  logic [DW-1:0] st_data, mw_data;
  logic rd_in_valid, rd_in_ready, rd_out_valid, rd_out_ready;
  logic full, empty;
  logic [CW-1:0] level;

  always #2.5 clk = ~clk;

  store_drain_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data), .rd_in_valid(rd_in_valid),
    .rd_in_ready(rd_in_ready), .rd_in_addr(rd_in_addr), .rd_out_valid(rd_out_valid),
    .rd_out_ready(rd_out_ready), .rd_out_addr(rd_out_addr), .full(full),
    .empty(empty), .level(level)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [AW-1:0] qa [DEPTH];
  logic [DW-1:0] qd [DEPTH];
  int qn = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #900000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog run did not complete");
    if (!done) finish_run();
  end

  initial begin
    int k = 0;
    rst_n = 1'b0;
    st_valid = 0; st_addr = '0; st_data = '0; mw_ready = 0;
    rd_in_valid = 0; rd_in_addr = '0; rd_out_ready = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "empty in reset", 32'(empty), 1);
    chk("R1", "level in reset", 32'(level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #0.5;
    chk("R1", "empty", 32'(empty), 1);
    chk("R1", "full", 32'(full), 0);
    chk("R1", "level", 32'(level), 0);
    chk("R1", "mw_valid", 32'(mw_valid), 0);

    for (int rp = 0; rp < 16; rp++) begin
      for (int vp = 0; vp < 16; vp++) begin
        for (int c = 0; c < 24; c++) begin
          bit exp_st_ready, exp_hit, do_pop, do_push;
          @(negedge clk);
          st_valid     = vp[c % 4];
          mw_ready     = rp[(c + vp) % 4];
          st_addr      = AW'(k % 5);
          st_data      = DW'(k * 37 + 5);
          rd_in_valid  = ((k % 3) != 0);
          rd_in_addr   = AW'((k * 7 + 3) % 5);
          rd_out_ready = ((k % 4) != 1);
          #0.5;
          // R8, R5: flags and head against the model
          chk("R8", "level", 32'(level), 32'(qn));
          chk("R8", "full", 32'(full), 32'(qn == DEPTH));
          chk("R8", "empty", 32'(empty), 32'(qn == 0));
          chk("R5", "mw_valid", 32'(mw_valid), 32'(qn > 0));
          if (qn > 0) begin
            chk("R4", "mw_addr order", 32'(mw_addr), 32'(qa[0]));
            chk("R4", "mw_data order", 32'(mw_data), 32'(qd[0]));
          end
          exp_st_ready = (qn < DEPTH) || mw_ready;
          if (qn < DEPTH)      chk("R2", "st_ready not full", 32'(st_ready), 32'(exp_st_ready));
          else if (!mw_ready)  chk("R3", "st_ready full stall", 32'(st_ready), 32'(exp_st_ready));
          else                 chk("R6", "st_ready full with drain", 32'(st_ready), 32'(exp_st_ready));
          exp_hit = 0;
          for (int i = 0; i < qn; i++) if (qa[i] == rd_in_addr) exp_hit = 1;
          chk("R7", "rd_out_valid", 32'(rd_out_valid), 32'(rd_in_valid && !exp_hit));
          chk("R7", "rd_in_ready", 32'(rd_in_ready), 32'(rd_out_ready && !exp_hit));
          if (rd_out_valid) chk("R7", "rd_out_addr", 32'(rd_out_addr), 32'(rd_in_addr));
          do_pop  = (qn > 0) && mw_ready;
          do_push = st_valid && exp_st_ready;
          if (do_pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
              qa[i] = qa[i + 1];
              qd[i] = qd[i + 1];
            end
            qn--;
          end
          if (do_push) begin
            qa[qn] = st_addr;
            qd[qn] = st_data;
            qn++;
          end
          k++;
        end
      end
    end
    finish_run();
  end
endmodule